// File: doc/BRIEF.md
# Unipolar SPWM Switch-State Decoder

This block turns a signed sine-reference sample into on/off commands for the five power switches of a single-phase, transformerless inverter. That inverter keeps the panel's negative terminal tied to grid neutral. Each half-cycle of the grid uses its own set of switches, so the decode is not the usual H-bridge mapping.

Inside the block, a symmetric triangular carrier is produced by an up/down counter. Its period is set by the system clock and the requested carrier rate. The reference is compared with the carrier to give the signal `cmp_pos`. The negated reference is compared with the same carrier to give `cmp_neg`. The sign of the reference gives the half-cycle flag `half_pos`. All three are registered on the clock edge at which the carrier moves.

A combinational table maps these three flags to the five gate commands and to a mode number from 1 to 4. The sine source, the current loop and the dead-time or overlap sequencing between switch states belong to other blocks.

Top module: `spwm_switch_decoder`

## Requirements
- R1: While reset is held, `carrier_o` equals -HALF, `cmp_pos_o` and `cmp_neg_o` are 0, `half_pos_o` is 1, `mode_o` is 2 and `gate_o` is 5'b11000.
- R2: Out of reset, the carrier starts at -HALF and rises. It changes by exactly one on every clock. It turns around at +HALF and at -HALF and always stays within that range, so one carrier period is 4*HALF clocks. HALF is CLK_HZ/(4*CARRIER_HZ).
- R3: After each clock edge, `cmp_pos_o` is 1 exactly when the reference held across that edge is strictly greater than the carrier value from the cycle before the edge.
- R4: After each clock edge, `cmp_neg_o` is 1 exactly when the arithmetic negation of that reference is strictly greater than that same carrier value. This holds even for the most negative reference code, with no wrap-around.
- R5: `half_pos_o` is registered on the same edge. It is 1 when the reference is zero or positive, and 0 when the reference is negative.
- R6: `gate_o[0]` (switch S1) = cmp_pos AND NOT cmp_neg AND half_pos.
- R7: `gate_o[2]` (switch S3) = NOT cmp_pos AND cmp_neg AND NOT half_pos.
- R8: `gate_o[3]` (S4) and `gate_o[4]` (S5) are always equal. Both are 1 exactly when cmp_pos equals cmp_neg.
- R9: `gate_o[1]` (switch S2) = NOT half_pos AND (cmp_pos equals cmp_neg).
- R10: `mode_o` follows these rules:
  - It is 1 when half_pos=1 and the two comparisons differ.
  - It is 2 when half_pos=1 and they agree.
  - It is 3 when half_pos=0 and they differ.
  - It is 4 when half_pos=0 and they agree.
- R11: Exactly one gate is on in modes 1 and 3. The gate pattern is 5'b11000 in mode 2 and 5'b11010 in mode 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_i | input | REF_W | Signed sine-reference sample |
| carrier_o | output | REF_W | Signed triangular carrier value |
| cmp_pos_o | output | 1 | Registered result of reference > carrier |
| cmp_neg_o | output | 1 | Registered result of negated reference > carrier |
| half_pos_o | output | 1 | Registered half-cycle flag, 1 for reference >= 0 |
| gate_o | output | 5 | Switch commands, bit 0 = S1 through bit 4 = S5 |
| mode_o | output | 3 | Operating mode, 1 to 4 |

## Verification
The assertions check the following on every cycle:
- the carrier moves by single steps and stays inside its range;
- both comparison flags match the previous cycle's reference and carrier;
- in the positive half-cycle, a true negated comparison implies a true direct comparison;
- S4 and S5 stay tied;
- each mode carries its own gate pattern.

Only the bench scenarios can show the following:
- where the carrier turns around, and its period;
- that a reference of exactly zero counts as the positive half-cycle;
- that the comparison is strict when the reference equals the carrier;
- that the most negative reference code and over-range references saturate correctly.

// File: rtl/spwm_pkg.sv
`timescale 1ns/1ps
package spwm_pkg;

    typedef enum logic [2:0] {
        MODE_POS_ACTIVE = 3'd1,
        MODE_POS_ZERO   = 3'd2,
        MODE_NEG_ACTIVE = 3'd3,
        MODE_NEG_ZERO   = 3'd4
    } spwm_mode_e;

    localparam int GATE_N  = 5;
    localparam int G_S1    = 0;
    localparam int G_S2    = 1;
    localparam int G_S3    = 2;
    localparam int G_S4    = 3;
    localparam int G_S5    = 4;

    typedef struct packed {
        logic above;
        logic below;
        logic half;
    } cmp_state_t;

endpackage

// File: rtl/spwm_carrier.sv
`timescale 1ns/1ps
module spwm_carrier #(
    parameter int HALF  = 8,
    parameter int CNT_W = $clog2(2*HALF+1)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(2*HALF);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             up;
    } car_t;

    car_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.up) begin
            if (st_q.cnt == TOP) begin
                st_d.cnt = TOP - 1'b1;
                st_d.up  = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            if (st_q.cnt == '0) begin
                st_d.cnt = CNT_W'(1);
                st_d.up  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.up  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/spwm_compare.sv
`timescale 1ns/1ps
module spwm_compare
    import spwm_pkg::*;
#(
    parameter int REF_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [REF_W-1:0] ref_i,
    input  logic signed [REF_W-1:0] carrier_i,
    output cmp_state_t              cmp_o
);
    cmp_state_t cmp_d, cmp_q;

    logic signed [REF_W:0] ref_x;
    logic signed [REF_W:0] neg_x;
    logic signed [REF_W:0] car_x;

    always_comb begin
        ref_x = $signed({ref_i[REF_W-1], ref_i});
        car_x = $signed({carrier_i[REF_W-1], carrier_i});
        neg_x = -ref_x;
        cmp_d.above = (ref_x > car_x);
        cmp_d.below = (neg_x > car_x);
        cmp_d.half  = ~ref_i[REF_W-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q.above <= 1'b0;
            cmp_q.below <= 1'b0;
            cmp_q.half  <= 1'b1;
        end else begin
            cmp_q <= cmp_d;
        end
    end

    assign cmp_o = cmp_q;
endmodule

// File: rtl/spwm_decode.sv
`timescale 1ns/1ps
module spwm_decode
    import spwm_pkg::*;
(
    input  cmp_state_t        cmp_i,
    output logic [GATE_N-1:0] gate_o,
    output spwm_mode_e        mode_o
);
    logic agree;

    always_comb begin
        agree          = ~(cmp_i.above ^ cmp_i.below);
        gate_o         = '0;
        gate_o[G_S1]   = cmp_i.above & ~cmp_i.below & cmp_i.half;
        gate_o[G_S2]   = ~cmp_i.half & agree;
        gate_o[G_S3]   = ~cmp_i.above & cmp_i.below & ~cmp_i.half;
        gate_o[G_S4]   = agree;
        gate_o[G_S5]   = agree;
        if (cmp_i.half) mode_o = agree ? MODE_POS_ZERO : MODE_POS_ACTIVE;
        else            mode_o = agree ? MODE_NEG_ZERO : MODE_NEG_ACTIVE;
    end
endmodule

// File: rtl/spwm_switch_decoder.sv
`timescale 1ns/1ps
module spwm_switch_decoder
    import spwm_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int CARRIER_HZ = 30_000,
    parameter int REF_W      = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [REF_W-1:0] ref_i,
    output logic signed [REF_W-1:0] carrier_o,
    output logic                    cmp_pos_o,
    output logic                    cmp_neg_o,
    output logic                    half_pos_o,
    output logic [4:0]              gate_o,
    output logic [2:0]              mode_o
);
    localparam int HALF  = CLK_HZ / (4 * CARRIER_HZ);
    localparam int CNT_W = $clog2(2*HALF+1);

    logic [CNT_W-1:0] cnt;
    logic [REF_W-1:0] cnt_ext;
    cmp_state_t       cmp;
    spwm_mode_e       mode;

    spwm_carrier #(.HALF(HALF), .CNT_W(CNT_W)) u_carrier (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_o (cnt)
    );

    assign cnt_ext   = REF_W'(cnt);
    assign carrier_o = $signed(cnt_ext - REF_W'(HALF));

    spwm_compare #(.REF_W(REF_W)) u_compare (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_i     (ref_i),
        .carrier_i (carrier_o),
        .cmp_o     (cmp)
    );

    spwm_decode u_decode (
        .cmp_i  (cmp),
        .gate_o (gate_o),
        .mode_o (mode)
    );

    assign cmp_pos_o  = cmp.above;
    assign cmp_neg_o  = cmp.below;
    assign half_pos_o = cmp.half;
    assign mode_o     = 3'(mode);
endmodule

// File: rtl/spwm_checker.sv
`timescale 1ns/1ps
module spwm_checker #(
    parameter int REF_W = 12,
    parameter int HALF  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [REF_W-1:0] ref_i,
    input  logic signed [REF_W-1:0] carrier_o,
    input  logic                    cmp_pos_o,
    input  logic                    cmp_neg_o,
    input  logic                    half_pos_o,
    input  logic [4:0]              gate_o,
    input  logic [2:0]              mode_o
);
    logic                  past_ok_q;
    logic signed [REF_W:0] ref_x;
    logic signed [REF_W:0] car_x;

    assign ref_x = $signed({ref_i[REF_W-1], ref_i});
    assign car_x = $signed({carrier_o[REF_W-1], carrier_o});

    always_ff @(posedge clk) begin
        if (!rst_n) past_ok_q <= 1'b0;
        else        past_ok_q <= 1'b1;
    end

    assert_carrier_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (car_x >= -HALF) && (car_x <= HALF));

    assert_carrier_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q |-> ((car_x - $past(car_x) == 1) || ($past(car_x) - car_x == 1)));

    assert_cmp_pos_R3: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q |-> (cmp_pos_o == ($past(ref_x) > $past(car_x))));

    assert_cmp_neg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q |-> (cmp_neg_o == ((-$past(ref_x)) > $past(car_x))));

    assert_half_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q |-> (half_pos_o == ($past(ref_x) >= 0)));

    assert_pos_half_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (half_pos_o && cmp_neg_o) |-> cmp_pos_o);

    assert_s1_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
        gate_o[0] |-> (half_pos_o && mode_o == 3'd1));

    assert_s3_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
        gate_o[2] |-> (!half_pos_o && mode_o == 3'd3));

    assert_s4_s5_tied_R8: assert property (@(posedge clk) disable iff (!rst_n)
        gate_o[3] == gate_o[4]);

    assert_s2_neg_R9: assert property (@(posedge clk) disable iff (!rst_n)
        gate_o[1] |-> (!half_pos_o && gate_o[3]));

    assert_mode_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o >= 3'd1) && (mode_o <= 3'd4));

    assert_single_active_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd1 || mode_o == 3'd3) |-> ($countones(gate_o) == 1));

    assert_zero_pos_pattern_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd2) |-> (gate_o == 5'b11000));

    assert_zero_neg_pattern_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd4) |-> (gate_o == 5'b11010));
endmodule

bind spwm_switch_decoder spwm_checker #(.REF_W(REF_W), .HALF(HALF)) u_spwm_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_i      (ref_i),
    .carrier_o  (carrier_o),
    .cmp_pos_o  (cmp_pos_o),
    .cmp_neg_o  (cmp_neg_o),
    .half_pos_o (half_pos_o),
    .gate_o     (gate_o),
    .mode_o     (mode_o)
);

// File: tb/tb_spwm_switch_decoder.sv
`timescale 1ns/1ps
module tb_spwm_switch_decoder;
    localparam int CLK_HZ     = 50_000_000;
    localparam int CARRIER_HZ = 1_562_500;
    localparam int REF_W      = 12;
    localparam int H          = CLK_HZ / (4 * CARRIER_HZ);

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic signed [REF_W-1:0] ref_i = '0;
    logic signed [REF_W-1:0] carrier_o;
    logic                    cmp_pos_o, cmp_neg_o, half_pos_o;
    logic [4:0]              gate_o;
    logic [2:0]              mode_o;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;
    int  mcnt   = 0;
    bit  mup    = 1'b1;

    always #10 clk = ~clk;

    spwm_switch_decoder #(.CLK_HZ(CLK_HZ), .CARRIER_HZ(CARRIER_HZ), .REF_W(REF_W)) dut (
        .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .carrier_o(carrier_o),
        .cmp_pos_o(cmp_pos_o), .cmp_neg_o(cmp_neg_o), .half_pos_o(half_pos_o),
        .gate_o(gate_o), .mode_o(mode_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [4:0] exp_gate(input bit p, input bit q, input bit r);
        bit agree = (p == q);
        return {agree, agree, ~p & q & ~r, ~r & agree, p & ~q & r};
    endfunction

    function automatic int exp_mode(input bit p, input bit q, input bit r);
        if (r) return (p != q) ? 1 : 2;
        return (p != q) ? 3 : 4;
    endfunction

    task automatic step(input int rv);
        int car_before;
        bit ep, eq, er;
        logic [4:0] eg;
        int em;
        ref_i = rv[REF_W-1:0];
        car_before = mcnt - H;
        @(posedge clk);
        if (mup) begin
            if (mcnt == 2*H) begin mcnt = 2*H - 1; mup = 1'b0; end
            else mcnt = mcnt + 1;
        end else begin
            if (mcnt == 0) begin mcnt = 1; mup = 1'b1; end
            else mcnt = mcnt - 1;
        end
        @(negedge clk);
        ep = (rv > car_before);
        eq = ((-rv) > car_before);
        er = (rv >= 0);
        eg = exp_gate(ep, eq, er);
        em = exp_mode(ep, eq, er);
        check(int'(carrier_o) == mcnt - H, "R2 carrier", int'(carrier_o), mcnt - H);
        check(cmp_pos_o == ep, "R3 cmp_pos", int'(cmp_pos_o), int'(ep));
        check(cmp_neg_o == eq, "R4 cmp_neg", int'(cmp_neg_o), int'(eq));
        check(half_pos_o == er, "R5 half_pos", int'(half_pos_o), int'(er));
        check(gate_o[0] == eg[0], "R6 S1", int'(gate_o[0]), int'(eg[0]));
        check(gate_o[2] == eg[2], "R7 S3", int'(gate_o[2]), int'(eg[2]));
        check(gate_o[4:3] == eg[4:3], "R8 S4/S5", int'(gate_o[4:3]), int'(eg[4:3]));
        check(gate_o[1] == eg[1], "R9 S2", int'(gate_o[1]), int'(eg[1]));
        check(int'(mode_o) == em, "R10 mode", int'(mode_o), em);
        if (em == 1 || em == 3)
            check($countones(gate_o) == 1, "R11 single gate", $countones(gate_o), 1);
    endtask

    task automatic hold(input int rv, input int n);
        for (int i = 0; i < n; i++) step(rv);
    endtask

    initial begin
        int unsigned seed_dummy;
        int rv;
        seed_dummy = $urandom(32'h5EED_0017);
        repeat (4) @(negedge clk);
        // R1: reset state
        check(int'(carrier_o) == -H, "R1 carrier", int'(carrier_o), -H);
        check(cmp_pos_o == 1'b0 && cmp_neg_o == 1'b0, "R1 cmp", int'({cmp_pos_o, cmp_neg_o}), 0);
        check(half_pos_o == 1'b1, "R1 half_pos", int'(half_pos_o), 1);
        check(mode_o == 3'd2, "R1 mode", int'(mode_o), 2);
        check(gate_o == 5'b11000, "R1 gate", int'(gate_o), 24);
        rst_n = 1'b1;
        mcnt = 0; mup = 1'b1;
        // R5: zero reference is positive half, comparisons agree
        hold(0, 4*H + 3);
        // R3 R6: full-scale positive saturates to mode 1
        hold(2047, 4*H);
        // R4 R7: most negative code, negation must not wrap
        hold(-2048, 4*H);
        // R3: strict compare where reference equals carrier
        hold(3, 4*H);
        hold(-3, 4*H);
        hold(-1, 4*H);
        // R2: carrier extremes
        hold(H, 4*H);
        hold(-H, 4*H);
        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 7) == 0) rv = int'($signed(12'($urandom)));
            else rv = int'($urandom_range(0, 2*H + 4)) - (H + 2);
            step(rv);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2ms;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all-requirements actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule